// File: doc/BRIEF.md
# Parallel Slave Configuration Port

This block is the target end of a 16-bit parallel configuration link. An external host drives the configuration clock, a chip select, a direction select and the data bus. The port passes each accepted word on to downstream configuration logic as a one-cycle strobe with the word beside it. It also runs a CRC over the words it has taken. After a fixed number of data words, one more word carries the expected CRC. A match raises the done output. A mismatch pulls the error output low.

Before loading starts, the port waits for an external hold input to be released. While the host has the port selected, it watches for a change of direction. Such a change sends the port into an abort state, and the port stays there until the host deselects it. When the host selects it again, loading resumes with the progress kept. The first word taken after an abort raises a one-cycle busy pulse. An active-low program input resets the port at any time, without waiting for a clock edge.

Top module: `pcfg_slave_port`

## Requirements
- R1: While `prog_n` is 0, and with no clock edge needed: `done` is 0, `err_n` is 1, and `busy`, `wr_valid` and `abort_flag` are all 0.
- R2: After reset the port takes no words while `hold_n` is sampled 0 at rising `cclk` edges. Loading starts at the first edge where `hold_n` is sampled 1. The word present at that edge is not taken, and words are taken from the next edge on.
- R3: While loading, a word is taken at a rising edge where `sel_n` = 0 and `dir_rd` = 0. For data words, `wr_valid` is 1 and `wr_data` holds the word for the cycle that follows that edge. Words presented with `sel_n` = 1 are ignored.
- R4: Suppose `dir_rd` = 1 was set while the port was deselected, and the port is then selected. No word is taken and no abort is raised.
- R5: Suppose `sel_n` is sampled 0 at two consecutive edges and `dir_rd` differs between them while loading. Then `abort_flag` is 1 after the second edge and that word is not taken. The port stays in abort for as long as `sel_n` keeps being sampled 0.
- R6: In abort, an edge that samples `sel_n` = 1 returns the port to loading. The count of words and the CRC from before the abort are kept.
- R7: The first word taken after an abort makes `busy` 1 for exactly the cycle after that edge. Later words leave `busy` at 0.
- R8: The CRC is CRC-16 with polynomial 0x1021 and initial value 0xFFFF. It is applied to each data word MSB first. The word taken after `WORD_COUNT` data words (default 4) is compared with it and is not forwarded on `wr_data`.
- R9: On a CRC match, `done` becomes 1 after that edge and stays 1 until reset, and `err_n` stays 1. Words after that are not taken (`wr_valid` stays 0).
- R10: On a CRC mismatch, `err_n` becomes 0 after that edge and stays 0 until reset, and `done` stays 0. Words after that are not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cclk | input | 1 | Configuration clock from the host, rising edge active |
| prog_n | input | 1 | Active-low asynchronous reset of the whole port |
| hold_n | input | 1 | Active-low hold-off; loading starts once it is sampled 1 |
| sel_n | input | 1 | Active-low chip select for the data bus |
| dir_rd | input | 1 | Direction select: 0 = host writes, 1 = host reads |
| data_in | input | 16 | Parallel configuration data bus |
| done | output | 1 | 1 once configuration finished with a matching CRC |
| err_n | output | 1 | Active-low CRC error flag (drives low only on error) |
| busy | output | 1 | One-cycle pulse on the first word taken after an abort |
| abort_flag | output | 1 | 1 while the port is in the abort state |
| wr_valid | output | 1 | Strobe: a data word was taken |
| wr_data | output | 16 | The data word taken, valid with `wr_valid` |

## Verification
The bench goes after a direction flip in the middle of a stream while the port is selected. A design that misses the flip would forward the word on the bus, and one that leaves abort without a deselect would accept words while still selected. The resend after the abort checks that progress is kept and that `busy` pulses only once. A design that reset its count would expect a different CRC and report an error. Two cases probe the edges of the stream. A read direction set up while deselected must neither abort nor load. A wrong check word must lower `err_n` and block any later word; a design that compared at the wrong word count would raise `done` or err at the wrong time.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;

  localparam int WORD_W = 16;
  localparam logic [WORD_W-1:0] CRC_POLY = 16'h1021;
  localparam logic [WORD_W-1:0] CRC_SEED = 16'hFFFF;

  typedef enum logic [2:0] {
    ST_HOLD  = 3'd0,
    ST_LOAD  = 3'd1,
    ST_ABORT = 3'd2,
    ST_DONE  = 3'd3,
    ST_FAIL  = 3'd4
  } cfg_state_t;

  // One data word folded into the CRC, most significant bit first.
  function automatic logic [WORD_W-1:0] crc_fold(input logic [WORD_W-1:0] acc,
                                                 input logic [WORD_W-1:0] word);
    logic [WORD_W-1:0] r;
    logic fb;
    r = acc;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      fb = r[WORD_W-1] ^ word[i];
      r  = r << 1;
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction

endpackage

// File: rtl/pcfg_bus_sampler.sv
module pcfg_bus_sampler (
  input  logic cclk,
  input  logic prog_n,
  input  logic sel_n,
  input  logic dir_rd,
  output logic abort_evt,
  output logic write_evt
);

  logic prev_sel_n;
  logic prev_dir;

  always_ff @(posedge cclk or negedge prog_n) begin
    if (!prog_n) begin
      prev_sel_n <= 1'b1;
      prev_dir   <= 1'b0;
    end else begin
      prev_sel_n <= sel_n;
      prev_dir   <= dir_rd;
    end
  end

  // Selected across two edges with a different direction: illegal flip.
  assign abort_evt = !sel_n && !prev_sel_n && (dir_rd != prev_dir);
  assign write_evt = !sel_n && !dir_rd && !abort_evt;

endmodule

// File: rtl/pcfg_crc_acc.sv
module pcfg_crc_acc
  import pcfg_pkg::*;
(
  input  logic              cclk,
  input  logic              prog_n,
  input  logic              step_en,
  input  logic [WORD_W-1:0] word,
  output logic [WORD_W-1:0] crc_q
);

  always_ff @(posedge cclk or negedge prog_n) begin
    if (!prog_n)      crc_q <= CRC_SEED;
    else if (step_en) crc_q <= crc_fold(crc_q, word);
  end

endmodule

// File: rtl/pcfg_seq.sv
module pcfg_seq
  import pcfg_pkg::*;
#(
  parameter int WORD_COUNT = 4
) (
  input  logic              cclk,
  input  logic              prog_n,
  input  logic              hold_n,
  input  logic              sel_n,
  input  logic              abort_evt,
  input  logic              write_evt,
  input  logic [WORD_W-1:0] word,
  input  logic [WORD_W-1:0] crc_q,
  output logic              in_load,
  output logic              accept_evt,
  output logic              data_accept,
  output logic              crc_ok_evt,
  output logic              crc_bad_evt,
  output logic              done,
  output logic              err_n,
  output logic              busy,
  output logic              abort_flag,
  output logic              wr_valid,
  output logic [WORD_W-1:0] wr_data
);

  localparam int CNT_W = $clog2(WORD_COUNT + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WORD_COUNT);

  cfg_state_t       state_q, state_d;
  logic [CNT_W-1:0] cnt_q;
  logic             post_abort_q;
  logic             data_phase;
  logic             check_evt;

  assign in_load     = (state_q == ST_LOAD);
  assign data_phase  = (cnt_q < LAST_CNT);
  assign accept_evt  = in_load && write_evt;
  assign data_accept = accept_evt && data_phase;
  assign check_evt   = accept_evt && !data_phase;
  assign crc_ok_evt  = check_evt && (word == crc_q);
  assign crc_bad_evt = check_evt && (word != crc_q);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_HOLD:  if (hold_n) state_d = ST_LOAD;
      ST_LOAD: begin
        if (abort_evt)        state_d = ST_ABORT;
        else if (crc_ok_evt)  state_d = ST_DONE;
        else if (crc_bad_evt) state_d = ST_FAIL;
      end
      ST_ABORT: if (sel_n) state_d = ST_LOAD;
      ST_DONE:  state_d = ST_DONE;
      ST_FAIL:  state_d = ST_FAIL;
      default:  state_d = ST_HOLD;
    endcase
  end

  always_ff @(posedge cclk or negedge prog_n) begin
    if (!prog_n) begin
      state_q      <= ST_HOLD;
      cnt_q        <= '0;
      post_abort_q <= 1'b0;
      busy         <= 1'b0;
      wr_valid     <= 1'b0;
      wr_data      <= '0;
    end else begin
      state_q  <= state_d;
      wr_valid <= data_accept;
      busy     <= accept_evt && post_abort_q;
      if (data_accept) begin
        cnt_q   <= cnt_q + 1'b1;
        wr_data <= word;
      end
      if (state_q == ST_ABORT && sel_n) post_abort_q <= 1'b1;
      else if (accept_evt)              post_abort_q <= 1'b0;
    end
  end

  assign done       = (state_q == ST_DONE);
  assign err_n      = (state_q != ST_FAIL);
  assign abort_flag = (state_q == ST_ABORT);

endmodule

// File: rtl/pcfg_slave_port.sv
module pcfg_slave_port
  import pcfg_pkg::*;
#(
  parameter int WORD_COUNT = 4
) (
  input  logic              cclk,
  input  logic              prog_n,
  input  logic              hold_n,
  input  logic              sel_n,
  input  logic              dir_rd,
  input  logic [WORD_W-1:0] data_in,
  output logic              done,
  output logic              err_n,
  output logic              busy,
  output logic              abort_flag,
  output logic              wr_valid,
  output logic [WORD_W-1:0] wr_data
);

  logic              abort_evt;
  logic              write_evt;
  logic              in_load;
  logic              accept_evt;
  logic              data_accept;
  logic              crc_ok_evt;
  logic              crc_bad_evt;
  logic [WORD_W-1:0] crc_q;

  pcfg_bus_sampler u_sampler (
    .cclk      (cclk),
    .prog_n    (prog_n),
    .sel_n     (sel_n),
    .dir_rd    (dir_rd),
    .abort_evt (abort_evt),
    .write_evt (write_evt)
  );

  pcfg_crc_acc u_crc (
    .cclk    (cclk),
    .prog_n  (prog_n),
    .step_en (data_accept),
    .word    (data_in),
    .crc_q   (crc_q)
  );

  pcfg_seq #(.WORD_COUNT(WORD_COUNT)) u_seq (
    .cclk        (cclk),
    .prog_n      (prog_n),
    .hold_n      (hold_n),
    .sel_n       (sel_n),
    .abort_evt   (abort_evt),
    .write_evt   (write_evt),
    .word        (data_in),
    .crc_q       (crc_q),
    .in_load     (in_load),
    .accept_evt  (accept_evt),
    .data_accept (data_accept),
    .crc_ok_evt  (crc_ok_evt),
    .crc_bad_evt (crc_bad_evt),
    .done        (done),
    .err_n       (err_n),
    .busy        (busy),
    .abort_flag  (abort_flag),
    .wr_valid    (wr_valid),
    .wr_data     (wr_data)
  );

endmodule

// File: rtl/pcfg_slave_port_chk.sv
module pcfg_slave_port_chk (
  input logic cclk,
  input logic prog_n,
  input logic sel_n,
  input logic done,
  input logic err_n,
  input logic busy,
  input logic abort_flag,
  input logic wr_valid,
  input logic abort_evt,
  input logic accept_evt,
  input logic crc_ok_evt,
  input logic in_load
);

  assert_abort_entry_R5: assert property (@(posedge cclk) disable iff (!prog_n)
    (in_load && abort_evt) |=> abort_flag);

  assert_abort_sticky_R5: assert property (@(posedge cclk) disable iff (!prog_n)
    (abort_flag && !sel_n) |=> abort_flag);

  assert_abort_blocks_R3: assert property (@(posedge cclk) disable iff (!prog_n)
    abort_flag |=> !wr_valid);

  assert_busy_cause_R7: assert property (@(posedge cclk) disable iff (!prog_n)
    busy |-> $past(accept_evt));

  assert_done_cause_R9: assert property (@(posedge cclk) disable iff (!prog_n)
    $rose(done) |-> $past(crc_ok_evt));

  assert_done_hold_R9: assert property (@(posedge cclk) disable iff (!prog_n)
    done |=> done);

  assert_done_excl_R10: assert property (@(posedge cclk) disable iff (!prog_n)
    !(done && !err_n));

  assert_no_data_after_done_R9: assert property (@(posedge cclk) disable iff (!prog_n)
    done |-> !wr_valid);

endmodule

bind pcfg_slave_port pcfg_slave_port_chk u_chk (
  .cclk       (cclk),
  .prog_n     (prog_n),
  .sel_n      (sel_n),
  .done       (done),
  .err_n      (err_n),
  .busy       (busy),
  .abort_flag (abort_flag),
  .wr_valid   (wr_valid),
  .abort_evt  (abort_evt),
  .accept_evt (accept_evt),
  .crc_ok_evt (crc_ok_evt),
  .in_load    (in_load)
);

// File: tb/pcfg_slave_port_tb.sv
module pcfg_slave_port_tb;

  localparam int CLK_P = 10;
  localparam int NROWS = 10;
  // Row: [22] sel_n [21] dir_rd [20] use computed crc [19:4] data
  //      [3] exp wr_valid [2] exp abort [1] exp busy [0] exp done
  localparam logic [22:0] ROWS [NROWS] = '{
    {1'b1, 1'b0, 1'b0, 16'hAAAA, 4'b0000},  // deselected: ignored (R3)
    {1'b0, 1'b0, 1'b0, 16'h1111, 4'b1000},  // taken (R3)
    {1'b0, 1'b0, 1'b0, 16'h2222, 4'b1000},
    {1'b0, 1'b1, 1'b0, 16'h3333, 4'b0100},  // flip while selected (R5)
    {1'b0, 1'b0, 1'b0, 16'h4444, 4'b0100},  // still selected: stays (R5)
    {1'b1, 1'b0, 1'b0, 16'h0000, 4'b0000},  // deselect leaves abort (R6)
    {1'b0, 1'b0, 1'b0, 16'h3333, 4'b1010},  // first word after abort (R7)
    {1'b0, 1'b0, 1'b0, 16'h4444, 4'b1000},
    {1'b0, 1'b0, 1'b1, 16'h0000, 4'b0001},  // check word matches (R8, R9)
    {1'b0, 1'b0, 1'b0, 16'h5555, 4'b0001}   // after done: ignored (R9)
  };

  logic        cclk = 1'b0;
  logic        prog_n = 1'b0;
  logic        hold_n = 1'b0;
  logic        sel_n = 1'b1;
  logic        dir_rd = 1'b0;
  logic [15:0] data_in = '0;
  logic        done, err_n, busy, abort_flag, wr_valid;
  logic [15:0] wr_data;

  int total = 0;
  int bad = 0;
  logic [15:0] ref_acc;

  always #(CLK_P/2) cclk = ~cclk;

  pcfg_slave_port u_dut (
    .cclk(cclk), .prog_n(prog_n), .hold_n(hold_n), .sel_n(sel_n),
    .dir_rd(dir_rd), .data_in(data_in), .done(done), .err_n(err_n),
    .busy(busy), .abort_flag(abort_flag), .wr_valid(wr_valid), .wr_data(wr_data)
  );

  function automatic logic [15:0] ref_crc(input logic [15:0] acc, input logic [15:0] w);
    logic [15:0] r;
    logic t;
    r = acc;
    for (int j = 0; j < 16; j++) begin
      t = r[15] ^ w[15-j];
      r = {r[14:0], 1'b0} ^ (t ? 16'h1021 : 16'h0000);
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic s, input logic d, input logic [15:0] w);
    @(negedge cclk);
    sel_n = s; dir_rd = d; data_in = w;
    @(posedge cclk);
    #1;
  endtask

  task automatic restart();
    @(negedge cclk);
    prog_n = 1'b0; hold_n = 1'b0; sel_n = 1'b1; dir_rd = 1'b0;
    #2;
    prog_n = 1'b1;
  endtask

  initial begin
    #(CLK_P * 50000);
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset state
    #3;
    check("R1 done in reset", {15'd0, done}, 16'd0);
    check("R1 err_n in reset", {15'd0, err_n}, 16'd1);
    check("R1 busy/valid/abort in reset", {13'd0, busy, wr_valid, abort_flag}, 16'd0);
    @(negedge cclk);
    prog_n = 1'b1;

    // R2: held off, words ignored
    for (int k = 0; k < 3; k++) begin
      drive(1'b0, 1'b0, 16'hDEAD);
      check("R2 no word while held", {15'd0, wr_valid}, 16'd0);
    end
    drive(1'b1, 1'b0, 16'h0000);
    hold_n = 1'b1;
    drive(1'b1, 1'b0, 16'h0000);
    check("R2 release edge takes nothing", {15'd0, wr_valid}, 16'd0);

    // Table walk
    ref_acc = 16'hFFFF;
    for (int i = 0; i < NROWS; i++) begin
      logic [22:0] r;
      logic [15:0] w;
      r = ROWS[i];
      w = r[20] ? ref_acc : r[19:4];
      drive(r[22], r[21], w);
      check($sformatf("R3 row%0d wr_valid", i), {15'd0, wr_valid}, {15'd0, r[3]});
      check($sformatf("R5 R6 row%0d abort_flag", i), {15'd0, abort_flag}, {15'd0, r[2]});
      check($sformatf("R7 row%0d busy", i), {15'd0, busy}, {15'd0, r[1]});
      check($sformatf("R9 row%0d done", i), {15'd0, done}, {15'd0, r[0]});
      check($sformatf("R10 row%0d err_n", i), {15'd0, err_n}, 16'd1);
      if (r[3]) begin
        check($sformatf("R3 row%0d wr_data", i), wr_data, w);
        ref_acc = ref_crc(ref_acc, w);
      end
    end

    // R1: asynchronous reset clears done between edges
    @(negedge cclk);
    #1;
    prog_n = 1'b0;
    #1;
    check("R1 async clear of done", {15'd0, done}, 16'd0);

    // R4, R8, R10: readback direction, then wrong check word
    restart();
    hold_n = 1'b1;
    drive(1'b1, 1'b1, 16'h0000);
    drive(1'b0, 1'b1, 16'h7777);
    check("R4 read dir no word", {15'd0, wr_valid}, 16'd0);
    check("R4 read dir no abort", {15'd0, abort_flag}, 16'd0);
    drive(1'b0, 1'b1, 16'h7777);
    check("R4 read dir still no abort", {14'd0, abort_flag, wr_valid}, 16'd0);
    drive(1'b1, 1'b0, 16'h0000);
    ref_acc = 16'hFFFF;
    for (int k = 0; k < 4; k++) begin
      logic [15:0] w;
      w = 16'hA5A5 ^ 16'(k * 16'h0101);
      drive(1'b0, 1'b0, w);
      check("R3 word taken in second run", wr_data, w);
      ref_acc = ref_crc(ref_acc, w);
    end
    drive(1'b0, 1'b0, ref_acc ^ 16'h0001);
    check("R10 err_n low on mismatch", {15'd0, err_n}, 16'd0);
    check("R10 done stays low", {15'd0, done}, 16'd0);
    check("R8 check word not forwarded", {15'd0, wr_valid}, 16'd0);
    drive(1'b0, 1'b0, 16'h1234);
    check("R10 word after error ignored", {15'd0, wr_valid}, 16'd0);
    check("R10 err_n held", {15'd0, err_n}, 16'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule